// File: doc/BRIEF.md
# Register-Controlled Clock Root Slice

This block produces one derived clock from a bank of eight candidate clocks. It is programmed through a single 32-bit control word. A write strobe in the configuration clock domain loads four fields: a source select, a gate enable, a pre-divide ratio and a post-divide ratio.

The selected clock passes through a glitch-free latch gate. It is then divided twice: first by the pre-divider, and then by the post-divider, which is clocked from the pre-divider's output. Each ratio field holds the ratio minus one. Each stage forwards its input unchanged when its ratio is one. A ratio change is adopted only when the stage finishes its current period.

A core build option, `CORE = 1`, keeps a single three-bit divider and no pre-divide stage. The control word can be read back at any time. Bits that are not fields always read as zero.

Top module: `clk_root_slice`

## Requirements
- R1: A write with `cfg_we` high at a rising `cfg_clk` edge loads the fields, which are visible on `cfg_rdata` from the next cycle. The fields are source select at bits 26:24, gate enable at bit 28, pre-divide at bits 18:16 and post-divide at bits 5:0. Every other bit reads zero, whatever was written.
- R2: While `rst_n` is low, and afterwards until the first write, the control word reads 0 and `clk_out` is low with no edges.
- R3: The select field chooses input `src_clk[sel]`, so the output period scales with the period of the chosen source.
- R4: A pre-divide field value N divides the gated source by N+1, for ratios 1 to 8.
- R5: A post-divide field value M further divides the pre-divider output by M+1, for ratios 1 to 64. The output period is therefore Tsrc·(N+1)·(M+1).
- R6: A stage with ratio R ≥ 2 holds its output high for floor(R/2) input periods and low for the rest, which gives 50% duty for even R. A stage with ratio 1 forwards its input unchanged.
- R7: With the gate bit at 0, `clk_out` shows no edges. Setting the bit to 1 resumes the output. The gate enable changes only while the selected source is low.
- R8: A new ratio is taken up by a stage only at the end of its current period. When the ratio is switched between 6 and 4 on source 0 (4 ns), no high or low phase on the output is shorter than 8 ns.
- R9: With `CORE = 1`, only bits 2:0 form the divider, giving divide by 1 to 8. Bits 18:16 and 5:3 have no effect and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk | input | 1 | Configuration write clock |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to be written |
| cfg_rdata | output | 32 | Current control word (fields only) |
| src_clk | input | 8 | Candidate source clocks |
| clk_out | output | 1 | Derived clock |

## Verification
The bench sweeps every pre-divide ratio against post-divide ratios of 1, 2, 3, 6 and 64. For each pair it measures both the period and the high time. A stage whose pass-through at ratio 1 was wrong would show up as a doubled period or a frozen output. A wrong duty count would show as an odd high time on even ratios.

Every source is selected in turn, to catch a mis-wired mux. The gate is closed and then reopened, to catch edges that leak through. Ratios are switched mid-period at varying offsets: a stage that reloaded at once would emit a short phase, or a counter overrun that stretches a phase. In the core build, bits 18:16 and 5:3 are loaded with values that would change the rate if they were wrongly decoded.

// File: rtl/clk_root_slice.sv
module clk_root_slice #(
  parameter bit CORE  = 1'b0,
  parameter int SELW  = 3,
  parameter int PREW  = 3,
  parameter int POSTW = CORE ? 3 : 6
) (
  input  logic                   rst_n,
  input  logic                   cfg_clk,
  input  logic                   cfg_we,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [(1<<SELW)-1:0]   src_clk,
  output logic                   clk_out
);
  localparam int SEL_LSB  = 24;
  localparam int GATE_BIT = 28;
  localparam int PRE_LSB  = 16;
  localparam int POST_LSB = 0;
  localparam int CW       = (PREW > POSTW) ? PREW : POSTW;
  localparam int NSTG     = CORE ? 1 : 2;

  logic [SELW-1:0]  sel_q;
  logic             gate_q;
  logic [PREW-1:0]  pre_q;
  logic [POSTW-1:0] post_q;
  logic             unused_wbits;

  assign unused_wbits = ^cfg_wdata;

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= '0;
      gate_q <= 1'b0;
      pre_q  <= '0;
      post_q <= '0;
    end else if (cfg_we) begin
      sel_q  <= cfg_wdata[SEL_LSB +: SELW];
      gate_q <= cfg_wdata[GATE_BIT];
      pre_q  <= CORE ? '0 : cfg_wdata[PRE_LSB +: PREW];
      post_q <= cfg_wdata[POST_LSB +: POSTW];
    end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[SEL_LSB +: SELW]   = sel_q;
    cfg_rdata[GATE_BIT]          = gate_q;
    cfg_rdata[PRE_LSB +: PREW]   = pre_q;
    cfg_rdata[POST_LSB +: POSTW] = post_q;
  end

  logic mclk, en_l, gclk;
  assign mclk = src_clk[sel_q];

  always_latch
    if (!rst_n)     en_l = 1'b0;
    else if (!mclk) en_l = gate_q;

  assign gclk = mclk & en_l;

  logic [NSTG*CW-1:0] fld;
  logic [NSTG*CW-1:0] rq_all;
  logic [NSTG*CW-1:0] cnt_all;
  logic [NSTG:0]      sclk;

  if (CORE) begin : g_fld_core
    assign fld[CW-1:0] = CW'(post_q);
  end else begin : g_fld_full
    assign fld[CW-1:0]    = CW'(pre_q);
    assign fld[2*CW-1:CW] = CW'(post_q);
  end

  assign sclk[0] = gclk;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    logic [CW-1:0] rq, cnt, nf;
    logic [CW:0]   half, nxt;
    logic          oq;

    assign nf   = fld[g*CW +: CW];
    assign half = ({1'b0, rq} + 1'b1) >> 1;
    assign nxt  = {1'b0, cnt} + 1'b1;

    always_ff @(posedge sclk[g] or negedge rst_n)
      if (!rst_n) begin
        rq  <= '0;
        cnt <= '0;
        oq  <= 1'b0;
      end else if (cnt == rq) begin
        cnt <= '0;
        rq  <= nf;
        oq  <= (nf != '0);
      end else begin
        cnt <= cnt + 1'b1;
        oq  <= (nxt < half);
      end

    assign sclk[g+1]           = (rq == '0) ? sclk[g] : oq;
    assign rq_all[g*CW +: CW]  = rq;
    assign cnt_all[g*CW +: CW] = cnt;
  end

  assign clk_out = sclk[NSTG];
endmodule

// File: rtl/clk_root_slice_chk.sv
module clk_root_slice_chk #(
  parameter bit CORE = 1'b0,
  parameter int NSTG = 2,
  parameter int CW   = 6
) (
  input logic              rst_n,
  input logic              cfg_clk,
  input logic              cfg_we,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              mclk,
  input logic              en_l,
  input logic [NSTG:0]     sclk,
  input logic [NSTG*CW-1:0] rq_all,
  input logic [NSTG*CW-1:0] cnt_all
);
  localparam logic [31:0] FMASK = CORE ? 32'h1700_0007 : 32'h1707_003F;

  // R1
  wr_field_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & FMASK)));

  // R7
  always @(en_l)
    if (rst_n) gate_glitch_chk: assert (!mclk);

  for (genvar g = 0; g < NSTG; g++) begin : g_chk
    logic [CW-1:0] c, r;
    assign c = cnt_all[g*CW +: CW];
    assign r = rq_all[g*CW +: CW];

    // R8
    ratio_hold_chk: assert property (@(posedge sclk[g]) disable iff (!rst_n)
      (c != r) |=> $stable(r));

    // R5
    cnt_range_chk: assert property (@(posedge sclk[g]) disable iff (!rst_n)
      c <= r);
  end
endmodule

bind clk_root_slice clk_root_slice_chk #(.CORE(CORE), .NSTG(NSTG), .CW(CW)) u_chk (
  .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .mclk(mclk), .en_l(en_l), .sclk(sclk),
  .rq_all(rq_all), .cnt_all(cnt_all)
);

// File: tb/test_clk_root_slice.sv
`timescale 1ns/1ps
module test_clk_root_slice;
  logic        cfg_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rd_m, rd_c;
  logic [7:0]  src;
  logic        sc [8];
  logic        out_m, out_c, mon;
  logic        use_core = 1'b0;
  logic        win = 1'b0;
  int          n_chk = 0, n_fail = 0, ecnt = 0;
  realtime     last = 0, minw = 1e9;

  always #5 cfg_clk = ~cfg_clk;

  for (genvar gi = 0; gi < 8; gi++) begin : g_src
    initial begin
      sc[gi] = 1'b0;
      forever #(2.0 + gi) sc[gi] = ~sc[gi];
    end
    assign src[gi] = sc[gi];
  end

  clk_root_slice i_clk_root_slice (
    .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_m), .src_clk(src), .clk_out(out_m));

  clk_root_slice #(.CORE(1'b1)) i_clk_root_slice_core (
    .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_c), .src_clk(src), .clk_out(out_c));

  assign mon = use_core ? out_c : out_m;

  always @(posedge mon) ecnt++;
  always @(mon) begin
    if (win && (($realtime - last) < minw)) minw = $realtime - last;
    last = $realtime;
  end

  function automatic real tsrc(input int s);
    return 4.0 + 2.0 * s;
  endfunction

  function automatic real exp_hi(input real t, input int r1, input int r2);
    if (r2 > 1)      return (r2 / 2) * r1 * t;
    else if (r1 > 1) return (r1 / 2) * t;
    else             return t / 2.0;
  endfunction

  function automatic logic [31:0] word(input int s, input bit g, input int pre, input int post);
    return (32'(g) << 28) | (32'(s) << 24) | (32'(pre) << 16) | 32'(post);
  endfunction

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input real act, input real exp);
    chk((act > exp - 0.01) && (act < exp + 0.01), req, act, exp);
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge cfg_clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge cfg_clk);
    cfg_we = 1'b0;
  endtask

  task automatic meas(output real per, output real hi);
    realtime t0, t1, t2;
    repeat (4) @(posedge mon);
    t0 = $realtime;
    @(negedge mon);
    t1 = $realtime;
    @(posedge mon);
    t2 = $realtime;
    per = t2 - t0;
    hi = t1 - t0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    real per, hi;
    int  e0;
    int  pl [5] = '{0, 1, 2, 5, 63};

    #23;
    // R2: held in reset, then released with gate off
    chk(rd_m == 32'h0, "R2 reset readback", real'(rd_m), 0.0);
    rst_n = 1'b1;
    e0 = ecnt;
    #500;
    chk(ecnt == e0 && out_m == 1'b0, "R2 no edges after reset", real'(ecnt - e0), 0.0);
    chk(rd_c == 32'h0, "R2 core reset readback", real'(rd_c), 0.0);

    // R1: field decode, other bits dropped (gate off keeps clocks frozen)
    wr(32'hEFFF_FFFF);
    chk(rd_m == 32'h0707_003F, "R1 readback all ones", real'(rd_m), real'(32'h0707_003F));
    chk(rd_c == 32'h0700_0007, "R9 core readback all ones", real'(rd_c), real'(32'h0700_0007));
    wr(32'h4A5A_5A5A);
    chk(rd_m == 32'h0202_001A, "R1 readback pattern", real'(rd_m), real'(32'h0202_001A));
    chk(rd_c == 32'h0200_0002, "R9 core readback pattern", real'(rd_c), real'(32'h0200_0002));
    wr(32'hE8F8_FFC0);
    chk(rd_m == 32'h0, "R1 non-field bits ignored", real'(rd_m), 0.0);

    // R4 R5 R6: divider sweep on source 0
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 5; k++) begin
        wr(word(0, 1'b1, p, pl[k]));
        meas(per, hi);
        chk_near((pl[k] == 0) ? "R4 pre-divide period" : "R5 cascaded period",
                 per, tsrc(0) * (p + 1) * (pl[k] + 1));
        chk_near("R6 high time", hi, exp_hi(tsrc(0), p + 1, pl[k] + 1));
      end
    end

    // R3: each source, ratio 2 x 3
    for (int s = 0; s < 8; s++) begin
      wr(word(s, 1'b1, 1, 2));
      meas(per, hi);
      chk_near("R3 source period", per, tsrc(s) * 6.0);
    end

    // R7: gate off then on
    wr(word(0, 1'b1, 1, 2));
    meas(per, hi);
    wr(word(0, 1'b0, 1, 2));
    #200;
    e0 = ecnt;
    #1000;
    chk(ecnt == e0, "R7 no edges while gated", real'(ecnt - e0), 0.0);
    wr(word(0, 1'b1, 1, 2));
    #100;
    e0 = ecnt;
    #960;
    chk((ecnt - e0) >= 39 && (ecnt - e0) <= 41, "R7 edges after ungating", real'(ecnt - e0), 40.0);

    // R8: ratio switches 6 <-> 4 at varying offsets
    wr(word(0, 1'b1, 0, 5));
    meas(per, hi);
    for (int t = 0; t < 6; t++) begin
      minw = 1e9;
      @(posedge mon);
      #0.1 win = 1'b1;
      repeat (t + 1) @(negedge cfg_clk);
      wr(word(0, 1'b1, 0, (t % 2 == 0) ? 3 : 5));
      repeat (6) @(posedge mon);
      win = 1'b0;
      chk(minw > 7.99, "R8 min phase across switch", minw, 8.0);
    end

    // R9: core variant, only bits 2:0 divide
    use_core = 1'b1;
    wr(word(0, 1'b1, 7, 6'h3D));
    chk(rd_c == 32'h1000_0005, "R9 core readback", real'(rd_c), real'(32'h1000_0005));
    meas(per, hi);
    chk_near("R9 core period ratio 6", per, tsrc(0) * 6.0);
    chk_near("R9 core high time ratio 6", hi, tsrc(0) * 3.0);
    wr(word(2, 1'b1, 5, 6'h3F));
    meas(per, hi);
    chk_near("R9 core period ratio 8", per, tsrc(2) * 8.0);
    wr(word(1, 1'b1, 3, 6'h38));
    meas(per, hi);
    chk_near("R9 core pass-through period", per, tsrc(1));

    report();
    $finish;
  end
endmodule